// File: doc/BRIEF.md
# Window Scaler Source Address Stepper

This block walks the output area of a display window in raster order, one output pixel per clock. For each output pixel it names the source column and source row the scaler reads, plus the byte address of that source pixel in the frame buffer. The output area is `dst_w` × `dst_h` pixels, and the source image is `src_w` × `src_h` pixels. Two stepping accumulators produce the mapping, one per axis. Each accumulator carries 12 fraction bits, starts at zero phase and adds a fixed increment per step. The integer part of the accumulator (the bits above the 12 fraction bits) selects the source pixel or source line.

Software places the window configuration on the inputs and pulses `start` while the block is idle. The block latches the whole configuration on that edge and computes both increments. It then emits `dst_w × dst_h` results on consecutive cycles, marks the final one, and returns to idle. Alongside the walk, a combinational path widens a 16-bit 5-6-5 pixel to 8 bits per component when the latched format is the 16-bit one. The same path passes 32-bit pixels through unchanged.

Top module: `dda_scaler_stepper`

## Requirements
- R1: While reset is held, and after it is released, `busy`, `pix_valid` and `pix_last` are 0 and `pix_col`, `pix_row` and `pix_addr` are 0.
- R2: A `start` pulse while idle latches every configuration input and raises `busy` on that edge. The first result is valid one clock later and has column 0 and row 0.
- R3: Each axis has an increment equal to `floor(in × 4096 / max(out − 1, 1))`. The column for output x is `floor(x × inc / 4096)`.
- R4: Rows follow the same rule, applied to `src_h`, `dst_h` and the output line index.
- R5: A column or row that the formula places at or beyond the source size is clamped to source size − 1.
- R6: Results come out one per clock in raster order, with the column moving fastest. `pix_last` is high only on the final result. `busy` falls on that same edge, and `pix_valid` falls one clock later.
- R7: `pix_addr` = base + (y_off + row) × line_bytes + (x_off + col) × bytes_per_pixel. `bytes_per_pixel` is 2 when `fmt16` is 1 and 4 when it is 0.
- R8: `line_bytes` equals the latched `src_w` × bytes_per_pixel. This is also the horizontal source size in bytes.
- R9: A `start` pulse while `busy` is ignored. The walk in progress continues with its latched configuration.
- R10: With `fmt16` latched at 1, `px_in[15:0]` is read with blue in [15:11], green in [10:5] and red in [4:0], and `px_in[31:16]` is ignored. `px_out` is {red8, green8, blue8, 8'hFF} packed from bit 31 down. Each widened field is the field followed by its own top bits. With `fmt16` at 0, `px_out` equals `px_in`.
- R11: An output size of 1 on an axis gives a single step on that axis, at source index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a window walk (used only when idle) |
| fmt16 | input | 1 | 1: 16-bit 5-6-5 pixels, 0: 32-bit pixels |
| src_w | input | DIM_W | Source width in pixels |
| src_h | input | DIM_W | Source height in lines |
| dst_w | input | DIM_W | Output width in pixels |
| dst_h | input | DIM_W | Output height in lines |
| base_addr | input | ADDR_W | Frame buffer start byte address |
| x_off | input | DIM_W | Horizontal source offset in pixels |
| y_off | input | DIM_W | Vertical source offset in lines |
| px_in | input | 32 | Raw source pixel |
| px_out | output | 32 | Pixel widened to 8 bits per component |
| busy | output | 1 | Walk in progress |
| pix_valid | output | 1 | Result outputs hold a result |
| pix_col | output | DIM_W | Source column |
| pix_row | output | DIM_W | Source row |
| pix_addr | output | ADDR_W | Source byte address |
| pix_last | output | 1 | Final result of the walk |
| line_bytes | output | DIM_W+2 | Bytes per source line |

## Verification
A corrupted accumulator or increment shows at the ports on the next result. The column or row drifts off the floor formula, and the address moves with it by whole pixels or whole lines, so a per-result comparison catches it within one clock. A wrong step counter shows as a misplaced `pix_last` or as a wrong total count of results. A configuration register that a mid-walk `start` overwrites shows as an address jump on the result that follows. The vectors include exact-division sizes, where clamping matters, and single-pixel outputs.

// File: rtl/dda_scaler_pkg.sv
package dda_scaler_pkg;

  localparam int FRAC_W = 12;

  // Widen a 5-6-5 word (blue high, red low) to {r8, g8, b8, a8}.
  function automatic logic [31:0] widen_565(input logic [15:0] p);
    logic [7:0] r8, g8, b8;
    r8 = {p[4:0],   p[4:2]};
    g8 = {p[10:5],  p[10:9]};
    b8 = {p[15:11], p[15:13]};
    return {r8, g8, b8, 8'hFF};
  endfunction

endpackage

// File: rtl/dda_axis.sv
module dda_axis
  import dda_scaler_pkg::*;
#(
  parameter int DIM_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [DIM_W-1:0] in_size,
  input  logic [DIM_W-1:0] out_size,
  output logic [DIM_W-1:0] src,
  output logic             at_end,
  output logic [DIM_W-1:0] in_q
);
  localparam int ACC_W = DIM_W + FRAC_W;

  logic [DIM_W-1:0] out_q, cnt, in_last, out_last, whole;
  logic [ACC_W-1:0] inc_q, acc;

  function automatic logic [ACC_W-1:0] dda_step(input logic [DIM_W-1:0] n_in,
                                                input logic [DIM_W-1:0] n_out);
    logic [DIM_W-1:0] den;
    den = (n_out > DIM_W'(1)) ? n_out - DIM_W'(1) : DIM_W'(1);
    return {n_in, {FRAC_W{1'b0}}} / ACC_W'(den);
  endfunction

  assign in_last  = (in_q  == '0) ? '0 : in_q  - DIM_W'(1);
  assign out_last = (out_q == '0) ? '0 : out_q - DIM_W'(1);
  assign whole    = acc[ACC_W-1:FRAC_W];
  assign src      = (whole > in_last) ? in_last : whole;
  assign at_end   = (cnt == out_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q  <= '0;
      out_q <= '0;
      inc_q <= '0;
      acc   <= '0;
      cnt   <= '0;
    end else if (load) begin
      in_q  <= in_size;
      out_q <= out_size;
      inc_q <= dda_step(in_size, out_size);
      acc   <= '0;
      cnt   <= '0;
    end else if (step) begin
      if (at_end) begin
        acc <= '0;
        cnt <= '0;
      end else begin
        acc <= acc + inc_q;
        cnt <= cnt + DIM_W'(1);
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= out_last); // R6
  AST_PHASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (src == '0)); // R2

endmodule

// File: rtl/dda_addr_gen.sv
module dda_addr_gen #(
  parameter int DIM_W  = 11,
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]  base,
  input  logic [DIM_W-1:0]   x_off,
  input  logic [DIM_W-1:0]   y_off,
  input  logic [DIM_W-1:0]   col,
  input  logic [DIM_W-1:0]   row,
  input  logic [DIM_W-1:0]   width,
  input  logic               fmt16,
  output logic [DIM_W+1:0]   line_bytes,
  output logic [ADDR_W-1:0]  addr
);
  logic [DIM_W:0]    px_idx, ln_idx;
  logic [ADDR_W-1:0] ln_part, px_part;

  assign line_bytes = fmt16 ? {1'b0, width, 1'b0} : {width, 2'b00};
  assign px_idx     = {1'b0, x_off} + {1'b0, col};
  assign ln_idx     = {1'b0, y_off} + {1'b0, row};
  assign ln_part    = ADDR_W'(ln_idx) * ADDR_W'(line_bytes);
  assign px_part    = fmt16 ? (ADDR_W'(px_idx) << 1) : (ADDR_W'(px_idx) << 2);
  assign addr       = base + ln_part + px_part;

endmodule

// File: rtl/dda_px_expand.sv
module dda_px_expand
  import dda_scaler_pkg::*;
(
  input  logic        fmt16,
  input  logic [31:0] px_in,
  output logic [31:0] px_out
);
  assign px_out = fmt16 ? widen_565(px_in[15:0]) : px_in;
endmodule

// File: rtl/dda_scaler_stepper.sv
module dda_scaler_stepper #(
  parameter int DIM_W  = 11,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              fmt16,
  input  logic [DIM_W-1:0]  src_w,
  input  logic [DIM_W-1:0]  src_h,
  input  logic [DIM_W-1:0]  dst_w,
  input  logic [DIM_W-1:0]  dst_h,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [DIM_W-1:0]  x_off,
  input  logic [DIM_W-1:0]  y_off,
  input  logic [31:0]       px_in,
  output logic [31:0]       px_out,
  output logic              busy,
  output logic              pix_valid,
  output logic [DIM_W-1:0]  pix_col,
  output logic [DIM_W-1:0]  pix_row,
  output logic [ADDR_W-1:0] pix_addr,
  output logic              pix_last,
  output logic [DIM_W+1:0]  line_bytes
);
  logic              accept, h_end, v_end, frame_end, v_step;
  logic [DIM_W-1:0]  h_src, v_src, h_in, v_in;
  logic [ADDR_W-1:0] addr_d, cfg_base;
  logic [DIM_W-1:0]  cfg_xo, cfg_yo;
  logic              cfg_fmt16;

  assign accept    = start & ~busy;
  assign v_step    = busy & h_end;
  assign frame_end = busy & h_end & v_end;

  dda_axis #(.DIM_W(DIM_W)) u_h_axis (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(busy),
    .in_size(src_w), .out_size(dst_w),
    .src(h_src), .at_end(h_end), .in_q(h_in)
  );

  dda_axis #(.DIM_W(DIM_W)) u_v_axis (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(v_step),
    .in_size(src_h), .out_size(dst_h),
    .src(v_src), .at_end(v_end), .in_q(v_in)
  );

  dda_addr_gen #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_addr (
    .base(cfg_base), .x_off(cfg_xo), .y_off(cfg_yo),
    .col(h_src), .row(v_src), .width(h_in), .fmt16(cfg_fmt16),
    .line_bytes(line_bytes), .addr(addr_d)
  );

  dda_px_expand u_expand (
    .fmt16(cfg_fmt16), .px_in(px_in), .px_out(px_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cfg_fmt16 <= 1'b0;
      cfg_base  <= '0;
      cfg_xo    <= '0;
      cfg_yo    <= '0;
      pix_valid <= 1'b0;
      pix_col   <= '0;
      pix_row   <= '0;
      pix_addr  <= '0;
      pix_last  <= 1'b0;
    end else begin
      if (accept) begin
        busy      <= 1'b1;
        cfg_fmt16 <= fmt16;
        cfg_base  <= base_addr;
        cfg_xo    <= x_off;
        cfg_yo    <= y_off;
      end else if (frame_end) begin
        busy <= 1'b0;
      end
      pix_valid <= busy;
      pix_last  <= frame_end;
      if (busy) begin
        pix_col  <= h_src;
        pix_row  <= v_src;
        pix_addr <= addr_d;
      end
    end
  end

  AST_ORIGIN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_valid) |-> (pix_col == '0 && pix_row == '0)); // R2
  AST_COL_IN_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && h_in != '0) |-> (pix_col < h_in)); // R5
  AST_ROW_IN_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && v_in != '0) |-> (pix_row < v_in)); // R5
  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_last) |=> !pix_valid); // R6
  AST_HOLD_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(cfg_base) && $stable(cfg_fmt16) && $stable(h_in))); // R9
  AST_ALPHA_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fmt16 |-> (px_out[7:0] == 8'hFF)); // R10

endmodule

// File: tb/dda_scaler_stepper_tb.sv
`timescale 1ns/1ps
module dda_scaler_stepper_tb;
  localparam int DIM_W  = 11;
  localparam int ADDR_W = 32;
  localparam int NV     = 6;
  localparam int V_W   [NV] = '{8, 8, 3, 2, 5, 16};
  localparam int V_H   [NV] = '{6, 8, 2, 2, 4, 1};
  localparam int V_OW  [NV] = '{8, 4, 7, 2, 1, 5};
  localparam int V_OH  [NV] = '{6, 3, 5, 2, 1, 2};
  localparam int V_F   [NV] = '{0, 1, 1, 0, 0, 1};
  localparam int V_BASE[NV] = '{'h1000, 'h2000, 0, 'h40, 'h100, 'h8000};
  localparam int V_XO  [NV] = '{2, 0, 5, 0, 1, 3};
  localparam int V_YO  [NV] = '{1, 0, 3, 0, 2, 4};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, fmt16 = 1'b0;
  logic [DIM_W-1:0] src_w = '0, src_h = '0, dst_w = '0, dst_h = '0, x_off = '0, y_off = '0;
  logic [ADDR_W-1:0] base_addr = '0, pix_addr;
  logic [31:0] px_in = '0, px_out;
  logic busy, pix_valid, pix_last;
  logic [DIM_W-1:0] pix_col, pix_row;
  logic [DIM_W+1:0] line_bytes;

  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dda_scaler_stepper #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fmt16(fmt16),
    .src_w(src_w), .src_h(src_h), .dst_w(dst_w), .dst_h(dst_h),
    .base_addr(base_addr), .x_off(x_off), .y_off(y_off),
    .px_in(px_in), .px_out(px_out), .busy(busy), .pix_valid(pix_valid),
    .pix_col(pix_col), .pix_row(pix_row), .pix_addr(pix_addr),
    .pix_last(pix_last), .line_bytes(line_bytes)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Unclamped source index from the step rule.
  function automatic int raw_idx(input int i, input int n_in, input int n_out);
    int div = (n_out > 1) ? n_out - 1 : 1;
    int inc = (n_in * 4096) / div;
    return (i * inc) / 4096;
  endfunction

  function automatic logic [31:0] model_565(input logic [15:0] p);
    logic [4:0] b5 = p[15:11];
    logic [5:0] g6 = p[10:5];
    logic [4:0] r5 = p[4:0];
    return {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2], 8'hFF};
  endfunction

  task automatic drive_cfg(input int v);
    src_w = DIM_W'(V_W[v]); src_h = DIM_W'(V_H[v]);
    dst_w = DIM_W'(V_OW[v]); dst_h = DIM_W'(V_OH[v]);
    fmt16 = V_F[v][0]; base_addr = ADDR_W'(V_BASE[v]);
    x_off = DIM_W'(V_XO[v]); y_off = DIM_W'(V_YO[v]);
  endtask

  task automatic run_frame(input int v, input int inject_at);
    int bpp = (V_F[v] != 0) ? 2 : 4;
    int n = V_OW[v] * V_OH[v];
    @(negedge clk);
    drive_cfg(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2", "busy after start", 64'(busy), 64'd1);
    chk("R2", "valid before first", 64'(pix_valid), 64'd0);
    for (int y = 0; y < V_OH[v]; y++) begin
      for (int x = 0; x < V_OW[v]; x++) begin
        int k = y * V_OW[v] + x;
        int rc = raw_idx(x, V_W[v], V_OW[v]);
        int rr = raw_idx(y, V_H[v], V_OH[v]);
        int ec = (rc > V_W[v] - 1) ? V_W[v] - 1 : rc;
        int er = (rr > V_H[v] - 1) ? V_H[v] - 1 : rr;
        int ea = V_BASE[v] + (V_YO[v] + er) * V_W[v] * bpp + (V_XO[v] + ec) * bpp;
        @(negedge clk);
        if (k == inject_at) begin
          start = 1'b1; src_w = 3; dst_w = 9; fmt16 = ~fmt16;
          base_addr = 'h7777_0000; x_off = 9; y_off = 9;
        end else begin
          start = 1'b0;
        end
        chk("R6", "valid", 64'(pix_valid), 64'd1);
        chk((rc != ec) ? "R5" : "R3", "col", 64'(pix_col), 64'(ec));
        chk((rr != er) ? "R5" : "R4", "row", 64'(pix_row), 64'(er));
        chk((inject_at >= 0 && k > inject_at) ? "R9" : "R7", "addr", 64'(pix_addr), 64'(ea));
        chk("R6", "last", 64'(pix_last), 64'(k == n - 1));
        if (V_OW[v] == 1) chk("R11", "single column", 64'(pix_col), 64'd0);
      end
    end
    @(negedge clk);
    start = 1'b0;
    chk("R6", "valid after last", 64'(pix_valid), 64'd0);
    chk("R6", "busy after last", 64'(busy), 64'd0);
    chk("R8", "line bytes", 64'(line_bytes), 64'(V_W[v] * bpp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", 64'(busy), 64'd0);
    chk("R1", "valid in reset", 64'(pix_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "last after reset", 64'(pix_last), 64'd0);
    chk("R1", "col/row/addr after reset", {pix_addr, 10'd0, pix_col, pix_row} & 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);

    for (int v = 0; v < NV; v++) run_frame(v, -1);

    // Latched format is 16-bit after the last vector.
    foreach (V_BASE[i]) begin
      logic [15:0] p16 = 16'(V_BASE[i] * 7 + 16'hAD55 + i * 16'h0841);
      @(negedge clk);
      px_in = {16'hDEAD, p16};
      #1 chk("R10", "widen 565", 64'(px_out), 64'(model_565(p16)));
    end
    px_in = {16'h0000, 16'hF81F};
    #1 chk("R10", "widen F81F", 64'(px_out), 64'h0000_0000_FF00_FFFF);

    run_frame(0, -1);
    px_in = 32'h1234_5678;
    #1 chk("R10", "32-bit passthrough", 64'(px_out), 64'h1234_5678);

    run_frame(1, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1;
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule